// File: doc/BRIEF.md
# External Status Change Interrupt Latch

This block watches three modem/status inputs of one serial channel: carrier detect, sync/hunt and clear-to-send. Each input passes through a two-flop synchronizer, after which the block detects its changes. When the group external/status enable is high and the source's own bit in an 8-bit enable register is set, a change opens an external/status interrupt. The block then holds that interrupt and freezes the enabled status bits. Software clears the condition with a one-cycle "reset external/status" command. If an enabled input ended up at a different level from the one frozen, that is, it changed an odd number of times while the interrupt was held, the block raises a fresh interrupt at once. If it changed an even number of times, the block returns to idle.

The control is a three-state machine:
- ST_OPEN: idle. Latches follow the pins.
- ST_HELD: an interrupt is pending. Enabled latches are frozen.
- ST_REARM: a one-cycle gap after the command. The request is low in this state.

The transitions are:
- OPEN→HELD on a qualifying change.
- HELD→REARM on the command.
- REARM→HELD when a mismatch was captured at the command, or when a new qualifying change arrives.
- REARM→OPEN otherwise.
- Any state→OPEN on channel reset.

Top module: `extstat_irq_latch`

## Requirements
- R1: The enable register reads 0xF8 after `rst_n` or a `chan_rst` pulse. A one-cycle `en_wr` loads `en_wdata`. Bit 3 enables carrier detect, bit 4 enables sync/hunt and bit 5 enables clear-to-send.
- R2: The status bit of a source whose enable is clear reports the pin level, delayed by two clock edges through the synchronizer.
- R3: `status_byte` places carrier detect on bit 3, sync/hunt on bit 4 and clear-to-send on bit 5. Its other bits read 0. An enabled source shows its latched value.
- R4: A change raises `ext_irq` only when `grp_en` and that source's enable bit are both set.
- R5: While `ext_irq` is high, the status bits of enabled sources do not change, whatever the pins do.
- R6: On the command while an interrupt is pending, `ext_irq` goes low for one cycle. It returns high on the following cycle only if an enabled source changed an odd number of times while the interrupt was held.
- R7: A level already present on a pin when its enable bit is set causes no interrupt.
- R8: The command has no effect when no interrupt is pending.
- R9: Enable bits 0, 1, 2, 6 and 7 are stored and read back but cause no interrupt.
- R10: `ext_irq` rises after the third rising clock edge that follows a pin change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| chan_rst | input | 1 | Synchronous channel reset pulse |
| dcd_pin | input | 1 | Carrier detect input (asynchronous) |
| sync_pin | input | 1 | Sync/hunt input (asynchronous) |
| cts_pin | input | 1 | Clear-to-send input (asynchronous) |
| grp_en | input | 1 | Group external/status interrupt enable |
| en_wr | input | 1 | Enable register write strobe |
| en_wdata | input | 8 | Enable register write data |
| rst_ext_cmd | input | 1 | Reset external/status command pulse |
| en_q | output | 8 | Enable register contents |
| status_byte | output | 8 | Status bits (latched or live) |
| ext_irq | output | 1 | External/status interrupt request |

## Verification
The hardest case to reach from the ports is the command arriving while an enabled input has toggled several times during one held interrupt. The parity of those toggles alone decides whether the request comes back after the one-cycle gap. Directed sequences toggle a pin once and twice inside a held interrupt before issuing the command. Seeded random sequences mix toggles, commands, enable writes and group-enable changes, so odd and even counts also occur across several sources at once. A reference model in the bench tracks the frozen latches and compares the outcome after each step.

// File: rtl/xsl_pkg.sv
package xsl_pkg;
    localparam int NSRC = 3;
    localparam int EN_W = 8;
    localparam logic [EN_W-1:0] EN_RESET = 8'hF8;

    typedef enum logic [1:0] {
        ST_OPEN  = 2'd0,
        ST_HELD  = 2'd1,
        ST_REARM = 2'd2
    } xsl_state_e;

    // Status/enable bit position of each source: 0 carrier, 1 sync, 2 cts
    function automatic int src_bit(input int idx);
        case (idx)
            0:       return 3;
            1:       return 4;
            default: return 5;
        endcase
    endfunction
endpackage

// File: rtl/xsl_sync.sv
module xsl_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_in,
    output logic [W-1:0] sync_out
);
    logic [W-1:0] stage1_q;
    logic [W-1:0] stage2_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1_q <= '0;
            stage2_q <= '0;
        end else begin
            stage1_q <= async_in;
            stage2_q <= stage1_q;
        end
    end

    assign sync_out = stage2_q;
endmodule

// File: rtl/xsl_srcbank.sv
module xsl_srcbank #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] live,
    input  logic [N-1:0] en_bits,
    input  logic         freeze,
    output logic [N-1:0] status,
    output logic         edge_hit,
    output logic         mismatch
);
    logic [N-1:0] live_d_q;
    logic [N-1:0] latch_q;
    logic [N-1:0] edge_v;
    logic [N-1:0] diff_v;

    for (genvar i = 0; i < N; i++) begin : g_src
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                live_d_q[i] <= 1'b0;
                latch_q[i]  <= 1'b0;
            end else begin
                live_d_q[i] <= live[i];
                if (!(freeze && en_bits[i]))
                    latch_q[i] <= live[i];
            end
        end
        assign edge_v[i] = en_bits[i] && (live[i] != live_d_q[i]);
        assign diff_v[i] = en_bits[i] && (live[i] != latch_q[i]);
        assign status[i] = en_bits[i] ? latch_q[i] : live[i];
    end

    assign edge_hit = |edge_v;
    assign mismatch = |diff_v;

    // R5: enabled latches hold while the interrupt is pending
    a_r5_frozen_latch: assert property (@(posedge clk) disable iff (!rst_n)
        freeze |=> ((latch_q & $past(en_bits)) == ($past(latch_q) & $past(en_bits))));
endmodule

// File: rtl/xsl_ctrl.sv
module xsl_ctrl
    import xsl_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            chan_rst,
    input  logic            grp_en,
    input  logic            cmd,
    input  logic            en_wr,
    input  logic [EN_W-1:0] en_wdata,
    input  logic            edge_hit,
    input  logic            mismatch,
    output logic [EN_W-1:0] en_q,
    output logic            freeze,
    output logic            irq
);
    xsl_state_e st_q, st_d;
    logic       refire_q;

    // Enable register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        en_q <= EN_RESET;
        else if (chan_rst) en_q <= EN_RESET;
        else if (en_wr)    en_q <= en_wdata;
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= ST_OPEN;
            refire_q <= 1'b0;
        end else begin
            st_q     <= st_d;
            refire_q <= (st_q == ST_HELD) && cmd && grp_en && mismatch && !chan_rst;
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_OPEN:  if (grp_en && edge_hit) st_d = ST_HELD;
            ST_HELD:  if (cmd) st_d = ST_REARM;
            ST_REARM: st_d = (refire_q || (grp_en && edge_hit)) ? ST_HELD : ST_OPEN;
            default:  st_d = ST_OPEN;
        endcase
        if (chan_rst) st_d = ST_OPEN;
    end

    // Outputs
    always_comb begin
        irq    = (st_q == ST_HELD);
        freeze = (st_q == ST_HELD) && !cmd;
    end

    a_r1_chan_reset: assert property (@(posedge clk) disable iff (!rst_n)
        chan_rst |=> (en_q == EN_RESET && !irq));
    a_r4_group_gate: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && !grp_en) |=> (st_q != ST_HELD));
    a_r6_rearm_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_HELD && cmd && !chan_rst) |=> (st_q == ST_REARM && !irq));
    a_r8_cmd_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_OPEN && cmd && !(grp_en && edge_hit) && !chan_rst) |=> (st_q == ST_OPEN));
endmodule

// File: rtl/extstat_irq_latch.sv
module extstat_irq_latch
    import xsl_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       chan_rst,
    input  logic       dcd_pin,
    input  logic       sync_pin,
    input  logic       cts_pin,
    input  logic       grp_en,
    input  logic       en_wr,
    input  logic [7:0] en_wdata,
    input  logic       rst_ext_cmd,
    output logic [7:0] en_q,
    output logic [7:0] status_byte,
    output logic       ext_irq
);
    logic [NSRC-1:0] pins;
    logic [NSRC-1:0] live;
    logic [NSRC-1:0] en_bits;
    logic [NSRC-1:0] status;
    logic            edge_hit;
    logic            mismatch;
    logic            freeze;

    assign pins = {cts_pin, sync_pin, dcd_pin};

    for (genvar i = 0; i < NSRC; i++) begin : g_en
        assign en_bits[i] = en_q[src_bit(i)];
    end

    always_comb begin
        status_byte = '0;
        for (int i = 0; i < NSRC; i++)
            status_byte[src_bit(i)] = status[i];
    end

    xsl_sync #(.W(NSRC)) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .async_in (pins),
        .sync_out (live)
    );

    xsl_srcbank #(.N(NSRC)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .live     (live),
        .en_bits  (en_bits),
        .freeze   (freeze),
        .status   (status),
        .edge_hit (edge_hit),
        .mismatch (mismatch)
    );

    xsl_ctrl u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .chan_rst (chan_rst),
        .grp_en   (grp_en),
        .cmd      (rst_ext_cmd),
        .en_wr    (en_wr),
        .en_wdata (en_wdata),
        .edge_hit (edge_hit),
        .mismatch (mismatch),
        .en_q     (en_q),
        .freeze   (freeze),
        .irq      (ext_irq)
    );
endmodule

// File: tb/sim_extstat_irq_latch.sv
module sim_extstat_irq_latch;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       chan_rst = 1'b0;
    logic [2:0] p = 3'b000;
    logic       grp_en = 1'b0;
    logic       en_wr = 1'b0;
    logic [7:0] en_wdata = 8'h00;
    logic       rst_ext_cmd = 1'b0;
    logic [7:0] en_q;
    logic [7:0] status_byte;
    logic       ext_irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    logic [2:0] m_live = 3'b000;
    logic [2:0] m_latch = 3'b000;
    logic       m_pend = 1'b0;
    logic [7:0] m_en = 8'hF8;
    logic       m_grp = 1'b0;

    always #4 clk = ~clk;

    extstat_irq_latch u0 (
        .clk(clk), .rst_n(rst_n), .chan_rst(chan_rst),
        .dcd_pin(p[0]), .sync_pin(p[1]), .cts_pin(p[2]),
        .grp_en(grp_en), .en_wr(en_wr), .en_wdata(en_wdata),
        .rst_ext_cmd(rst_ext_cmd), .en_q(en_q),
        .status_byte(status_byte), .ext_irq(ext_irq)
    );

    function automatic int pos(input int i);
        return 3 + i;
    endfunction

    function automatic logic [7:0] exp_status();
        logic [7:0] v = '0;
        for (int i = 0; i < 3; i++)
            v[pos(i)] = m_en[pos(i)] ? m_latch[i] : m_live[i];
        return v;
    endfunction

    function automatic void refresh();
        for (int i = 0; i < 3; i++)
            if (!(m_pend && m_en[pos(i)])) m_latch[i] = m_live[i];
    endfunction

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        chk(ext_irq == m_pend, {tag, " R4/R6 irq"}, ext_irq, m_pend);
        chk(status_byte == exp_status(), {tag, " R3/R5 status"}, status_byte, exp_status());
        chk(en_q == m_en, {tag, " R1 enable"}, en_q, m_en);
    endtask

    task automatic op_pin(input int i, input string tag);
        logic hit;
        p[i] = ~p[i];
        m_live[i] = p[i];
        hit = !m_pend && m_grp && m_en[pos(i)];
        refresh();
        m_pend = m_pend | hit;
        tick(5);
        check_all(tag);
    endtask

    task automatic op_en(input logic [7:0] v, input string tag);
        en_wdata = v; en_wr = 1'b1;
        tick(1);
        en_wr = 1'b0;
        m_en = v;
        refresh();
        tick(4);
        check_all(tag);
    endtask

    task automatic op_cmd(input string tag);
        logic mism;
        rst_ext_cmd = 1'b1;
        tick(1);
        rst_ext_cmd = 1'b0;
        if (m_pend) begin
            mism = 1'b0;
            for (int i = 0; i < 3; i++)
                if (m_en[pos(i)] && (m_latch[i] != m_live[i])) mism = 1'b1;
            m_pend = m_grp && mism;
            m_latch = m_live;
            refresh();
        end
        tick(4);
        check_all(tag);
    endtask

    task automatic op_grp(input logic v, input string tag);
        grp_en = v; m_grp = v;
        tick(5);
        check_all(tag);
    endtask

    task automatic op_chrst(input string tag);
        chan_rst = 1'b1;
        tick(1);
        chan_rst = 1'b0;
        m_en = 8'hF8; m_pend = 1'b0;
        refresh();
        tick(4);
        check_all(tag);
    endtask

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(3);
        // R1 reset state
        chk(en_q == 8'hF8, "R1 reset enable", en_q, 8'hF8);
        chk(ext_irq == 1'b0, "R1 reset irq", ext_irq, 0);
        chk(status_byte == 8'h00, "R3 reset status", status_byte, 0);

        // R2 live path with source disabled, two-edge delay
        op_en(8'h00, "R2 disable all");
        p[2] = 1'b1; m_live[2] = 1'b1; refresh();
        tick(1);
        chk(status_byte[5] == 1'b0, "R2 after one edge", status_byte[5], 0);
        tick(1);
        chk(status_byte[5] == 1'b1, "R2 after two edges", status_byte[5], 1);
        tick(3);
        check_all("R2 settled");

        // R7 level present before enable: no interrupt
        op_grp(1'b1, "R7 group on");
        op_en(8'h38, "R7 enable with high cts");
        chk(ext_irq == 1'b0, "R7 no irq on enable", ext_irq, 0);

        // R10 timing of irq after a change
        p[0] = 1'b1; m_live[0] = 1'b1; refresh(); m_pend = 1'b1;
        tick(2);
        chk(ext_irq == 1'b0, "R10 not yet after two edges", ext_irq, 0);
        tick(1);
        chk(ext_irq == 1'b1, "R10 high after three edges", ext_irq, 1);
        tick(2);
        check_all("R10 settled");

        // R5 freeze, R6 odd count re-fires with a one-cycle gap
        op_pin(1, "R5 toggle sync while held");
        rst_ext_cmd = 1'b1;
        tick(1);
        rst_ext_cmd = 1'b0;
        chk(ext_irq == 1'b0, "R6 gap cycle", ext_irq, 0);
        tick(1);
        chk(ext_irq == 1'b1, "R6 odd count refires", ext_irq, 1);
        m_latch = m_live; refresh();
        tick(3);
        check_all("R6 odd settled");

        // R6 even count: no refire
        op_pin(0, "R6 even first");
        op_pin(0, "R6 even second");
        op_cmd("R6 even clears");
        chk(ext_irq == 1'b0, "R6 even no irq", ext_irq, 0);

        // R8 command with nothing pending
        op_cmd("R8 idle command");

        // R4 group disabled blocks
        op_grp(1'b0, "R4 group off");
        op_pin(2, "R4 change with group off");
        chk(ext_irq == 1'b0, "R4 blocked", ext_irq, 0);
        op_grp(1'b1, "R4 group back on");

        // R9 unused enable bits
        op_en(8'hC7, "R9 only unused bits");
        op_pin(0, "R9 toggle");
        op_pin(1, "R9 toggle");
        op_pin(2, "R9 toggle");
        chk(ext_irq == 1'b0, "R9 no irq", ext_irq, 0);

        // R1 channel reset
        op_en(8'h08, "R1 write");
        op_pin(0, "R1 raise");
        op_chrst("R1 channel reset");

        // random mix
        void'($urandom(32'h5EED1));
        for (int k = 0; k < 400; k++) begin
            int r = $urandom % 12;
            if (r < 6)       op_pin($urandom % 3, "rand pin");
            else if (r < 8)  op_cmd("rand cmd");
            else if (r == 8) op_en($urandom % 256, "rand enable");
            else if (r == 9) op_grp(($urandom % 4) != 0, "rand group");
            else if (r == 10) op_en(8'h38, "rand enable all");
            else             op_chrst("rand chan reset");
        end

        done = 1;
        $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        #1200000;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("  Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule